// File: doc/BRIEF.md
# Shared Prescaler and Clock-Select Tick Stage

This block turns one base clock into a tick enable for each of five timer channels. The channels fall into two groups. Channels 0 and 1 form group 0 and channels 2, 3 and 4 form group 1. Each group has its own 8-bit prescaler. After the prescaler, each channel has a 4-bit selector code. The code picks a power-of-two divide of its group's prescaled rate, or it picks the group's external clock input. Nothing in the block makes a derived clock. All logic runs on `clk`, and each output is a one-cycle enable that the counters next to the block use to qualify their count.

Software writes two configuration words through a single-cycle write port. Address 0 is the prescaler word and address 1 is the selector word. A write to the prescaler word restarts both group prescalers and both divider-tap counters, so the first tick after the write comes a full interval later.

Each external clock input passes through a two-flop synchronizer and then a two-state edge tracker. In state EDGE_LOW, a high synchronized input emits one tick and moves the tracker to EDGE_HIGH. In EDGE_HIGH, a low synchronized input moves it back to EDGE_LOW and emits nothing.

Top module: `tick_clock_select`

## Requirements
- R1: While `rst_n` is low, `tick_en` is all zero. Both configuration words reset to zero.
- R2: The prescaler word holds prescaler 0 in bits 7:0 and prescaler 1 in bits 15:8. Channels 0 and 1 use prescaler 0. Channels 2 to 4 use prescaler 1.
- R3: A group with prescaler value p produces one prescaled pulse every p+1 cycles. The pulse never comes in two adjacent cycles unless p is 0.
- R4: Channel n reads its selector code c from bits 4n+3:4n of the selector word. When c is not an external code, the channel ticks once every (p+1)·2^(c+DIV_BASE) cycles.
- R5: A code whose bit is set in `EXT_MASK` selects the external clock. Channels 0 and 1 then follow `ext_src[0]`, and channels 2 to 4 follow `ext_src[1]`. The channel emits exactly one tick per rising edge of that input.
- R6: An external rising edge appears at `tick_en` after the third rising clock edge that samples the input high. The external tick lasts one cycle.
- R7: After a write to the prescaler word (`cfg_addr`=0), a divider-selected channel shows no tick until exactly (p+1)·2^(c+DIV_BASE) clock edges after the write edge.
- R8: Bits 19:16 of a prescaler-word write have no effect. A selector-word write (`cfg_addr`=1) changes only the selector codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe, one cycle |
| cfg_addr | input | 1 | 0 = prescaler word, 1 = selector word |
| cfg_wdata | input | 20 | Write data |
| ext_src | input | 2 | External clocks for group 0 and group 1 (asynchronous) |
| tick_en | output | 5 | Per-channel one-cycle tick enables |

## Verification
The bench builds two copies that share every input. The first uses DIV_BASE 0 and treats codes 5, 6 and 7 as external. The second uses DIV_BASE 1 and treats only code 4 as external. With this pairing the same selector code runs as a divider in one copy and as the external path in the other, and every divider interval in the second copy is twice the first. Random prescaler values stay small so that codes up to 7 finish within short windows. Directed windows cover prescaler 255, the power-on configuration, and groups programmed with different prescalers.

// File: rtl/tick_stage_pkg.sv
`timescale 1ns/1ps
package tick_stage_pkg;

    localparam int SEL_W   = 4;
    localparam int PRE_W   = 8;
    localparam int NUM_GRP = 2;

    typedef enum logic [0:0] {
        CFG_PRESCALE = 1'b0,
        CFG_SELECT   = 1'b1
    } cfg_addr_e;

    typedef enum logic [0:0] {
        EDGE_LOW  = 1'b0,
        EDGE_HIGH = 1'b1
    } edge_state_e;

    // Group that a channel belongs to: below the split point it is group 0.
    function automatic int grp_of(input int ch, input int split);
        return (ch < split) ? 0 : 1;
    endfunction

endpackage

// File: rtl/tick_prescale_group.sv
`timescale 1ns/1ps
module tick_prescale_group #(
    parameter int PRE_W = 8,
    parameter int TAP_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [PRE_W-1:0] limit,
    output logic             pre_tick,
    output logic [TAP_W-1:0] tap
);

    logic [PRE_W-1:0] cnt_q;
    logic [TAP_W-1:0] tap_q;

    // A restart cycle never reports a pulse, so the new interval is whole.
    assign pre_tick = (cnt_q == limit) && !restart;
    assign tap      = tap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tap_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
            tap_q <= '0;
        end else if (pre_tick) begin
            cnt_q <= '0;
            tap_q <= tap_q + 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/tick_ext_edge.sv
`timescale 1ns/1ps
module tick_ext_edge
    import tick_stage_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    output logic rise
);

    logic        sync1_q;
    logic        sync2_q;
    edge_state_e state_q;
    edge_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
        end else begin
            sync1_q <= ext_in;
            sync2_q <= sync1_q;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EDGE_LOW;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EDGE_LOW:  if (sync2_q)  state_d = EDGE_HIGH;
            EDGE_HIGH: if (!sync2_q) state_d = EDGE_LOW;
            default:   state_d = EDGE_LOW;
        endcase
    end

    // Outputs
    always_comb begin
        rise = 1'b0;
        unique case (state_q)
            EDGE_LOW:  rise = sync2_q;
            EDGE_HIGH: rise = 1'b0;
            default:   rise = 1'b0;
        endcase
    end

endmodule

// File: rtl/tick_channel_select.sv
`timescale 1ns/1ps
module tick_channel_select #(
    parameter int                     SEL_W    = 4,
    parameter int                     TAP_W    = 15,
    parameter int                     DIV_BASE = 0,
    parameter logic [(1<<SEL_W)-1:0]  EXT_MASK = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] code,
    input  logic             pre_tick,
    input  logic [TAP_W-1:0] tap,
    input  logic             ext_tick,
    output logic             tick_o
);

    localparam int EXP_W = $clog2(TAP_W + 1);

    logic [EXP_W-1:0] exp_w;
    logic [TAP_W-1:0] span;
    logic             use_ext;
    logic             tap_hit;
    logic             tick_d;
    logic             tick_q;

    always_comb begin
        exp_w   = EXP_W'(code) + EXP_W'(DIV_BASE);
        // Low exp_w bits set: the tap wraps when all of them are ones.
        span    = ~({TAP_W{1'b1}} << exp_w);
        tap_hit = ((tap & span) == span);
        use_ext = EXT_MASK[code];
        tick_d  = use_ext ? ext_tick : (pre_tick && tap_hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tick_q <= 1'b0;
        else        tick_q <= tick_d;
    end

    assign tick_o = tick_q;

endmodule

// File: rtl/tick_clock_select.sv
`timescale 1ns/1ps
module tick_clock_select
    import tick_stage_pkg::*;
#(
    parameter int                    NUM_CH   = 5,
    parameter int                    SPLIT_CH = 2,
    parameter int                    DIV_BASE = 0,
    parameter logic [(1<<SEL_W)-1:0] EXT_MASK = 16'h00E0,
    localparam int SEL_WORD_W = NUM_CH * SEL_W,
    localparam int PRE_WORD_W = NUM_GRP * PRE_W,
    localparam int CFG_W      = (SEL_WORD_W > PRE_WORD_W) ? SEL_WORD_W : PRE_WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic [NUM_GRP-1:0] ext_src,
    output logic [NUM_CH-1:0] tick_en
);

    localparam int TAP_W = (1 << SEL_W) - 1 + DIV_BASE;

    logic [PRE_WORD_W-1:0] presc_q;
    logic [SEL_WORD_W-1:0] sel_q;
    logic                  presc_load;
    logic                  sel_load;
    logic [NUM_GRP-1:0]    pre_tick_w;
    logic [NUM_GRP-1:0]    ext_tick_w;
    logic [TAP_W-1:0]      tap_w [NUM_GRP];

    assign presc_load = cfg_wr && (cfg_addr_e'(cfg_addr) == CFG_PRESCALE);
    assign sel_load   = cfg_wr && (cfg_addr_e'(cfg_addr) == CFG_SELECT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc_q <= '0;
            sel_q   <= '0;
        end else begin
            if (presc_load) presc_q <= cfg_wdata[PRE_WORD_W-1:0];
            if (sel_load)   sel_q   <= cfg_wdata[SEL_WORD_W-1:0];
        end
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        tick_prescale_group #(
            .PRE_W (PRE_W),
            .TAP_W (TAP_W)
        ) i_group (
            .clk      (clk),
            .rst_n    (rst_n),
            .restart  (presc_load),
            .limit    (presc_q[g*PRE_W +: PRE_W]),
            .pre_tick (pre_tick_w[g]),
            .tap      (tap_w[g])
        );

        tick_ext_edge i_ext (
            .clk    (clk),
            .rst_n  (rst_n),
            .ext_in (ext_src[g]),
            .rise   (ext_tick_w[g])
        );
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int G = grp_of(c, SPLIT_CH);
        tick_channel_select #(
            .SEL_W    (SEL_W),
            .TAP_W    (TAP_W),
            .DIV_BASE (DIV_BASE),
            .EXT_MASK (EXT_MASK)
        ) i_sel (
            .clk      (clk),
            .rst_n    (rst_n),
            .code     (sel_q[c*SEL_W +: SEL_W]),
            .pre_tick (pre_tick_w[G]),
            .tap      (tap_w[G]),
            .ext_tick (ext_tick_w[G]),
            .tick_o   (tick_en[c])
        );
    end

endmodule

// File: rtl/tick_clock_select_chk.sv
`timescale 1ns/1ps
module tick_clock_select_chk
    import tick_stage_pkg::*;
#(
    parameter int NUM_CH   = 5,
    parameter int SPLIT_CH = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       presc_load,
    input logic [NUM_GRP*PRE_W-1:0]   presc_word,
    input logic [NUM_GRP-1:0]         pre_tick,
    input logic [NUM_GRP-1:0]         ext_tick,
    input logic [NUM_CH-1:0]          tick_en
);

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_quiet_in_reset_R1: assert (tick_en == '0)
                else $error("tick during reset");
        end
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp_chk
        assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
            presc_load |=> (presc_load ||
                            (pre_tick[g] == (presc_word[g*PRE_W +: PRE_W] == '0))));

        assert_prescale_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (pre_tick[g] && !presc_load && (presc_word[g*PRE_W +: PRE_W] != '0))
                |=> !pre_tick[g]);

        assert_ext_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
            ext_tick[g] |=> !ext_tick[g]);
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch_chk
        localparam int G = grp_of(c, SPLIT_CH);
        assert_tick_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
            tick_en[c] |-> $past(pre_tick[G] || ext_tick[G]));
    end

endmodule

bind tick_clock_select tick_clock_select_chk #(
    .NUM_CH   (NUM_CH),
    .SPLIT_CH (SPLIT_CH)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .presc_load (presc_load),
    .presc_word (presc_q),
    .pre_tick   (pre_tick_w),
    .ext_tick   (ext_tick_w),
    .tick_en    (tick_en)
);

// File: tb/test_tick_clock_select.sv
`timescale 1ns/1ps
module test_tick_clock_select;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_addr = 1'b0;
    logic [19:0] cfg_wdata = '0;
    logic [1:0]  ext_src = '0;
    logic [4:0]  tick_a;
    logic [4:0]  tick_b;
    int          checks = 0;
    int          fails = 0;

    always #4 clk = ~clk;   // 125 MHz

    tick_clock_select #(.DIV_BASE(0), .EXT_MASK(16'h00E0)) i_tick_clock_select (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .ext_src(ext_src), .tick_en(tick_a));

    tick_clock_select #(.DIV_BASE(1), .EXT_MASK(16'h0010)) i_tick_clock_select_b (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .ext_src(ext_src), .tick_en(tick_b));

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit is_ext(input int inst, input int code);
        if (inst == 0) return (code >= 5 && code <= 7);
        return (code == 4);
    endfunction

    // Interval in cycles of a divider channel; 0 for an external code.
    function automatic int period_of(input int inst, input int p, input int code);
        if (is_ext(inst, code)) return 0;
        return (p + 1) << (code + inst);
    endfunction

    task automatic wr(input bit addr, input logic [19:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = addr; cfg_wdata = d;
        @(posedge clk);
        #1;
        cfg_wr = 1'b0;
    endtask

    task automatic run_window(input int p0, input int p1, input logic [19:0] sel,
                              input string tag);
        int first [2][5];
        int cnt   [2][5];
        int last  [2][5];
        int bad   [2][5];
        int rises [2];
        int frise [2];
        int hp    [2];
        int ph    [2];
        int len, maxd, d, pc, code;
        logic [4:0] tk;
        logic [19:0] pw;
        maxd = 1;
        for (int i = 0; i < 2; i++)
            for (int c = 0; c < 5; c++) begin
                d = period_of(i, (c < 2) ? p0 : p1, int'(sel[4*c +: 4]));
                if (d > maxd) maxd = d;
                first[i][c] = -1; cnt[i][c] = 0; last[i][c] = 0; bad[i][c] = 0;
            end
        len = 3 * maxd + 40;
        for (int g = 0; g < 2; g++) begin
            rises[g] = 0; frise[g] = -1; ph[g] = 0;
            hp[g] = 2 + int'($urandom % 4);
        end
        wr(1'b1, sel);
        // R8: junk in bits 19:16 of the prescaler word must be ignored
        pw = {4'($urandom), 8'(p1), 8'(p0)};
        wr(1'b0, pw);
        for (int t = 0; t < len; t++) begin
            @(negedge clk);
            for (int i = 0; i < 2; i++) begin
                tk = (i == 0) ? tick_a : tick_b;
                for (int c = 0; c < 5; c++) begin
                    if (tk[c]) begin
                        d = period_of(i, (c < 2) ? p0 : p1, int'(sel[4*c +: 4]));
                        if (first[i][c] < 0) first[i][c] = t;
                        else if (d > 0 && (t - last[i][c]) != d) bad[i][c]++;
                        last[i][c] = t;
                        cnt[i][c]++;
                    end
                end
            end
            for (int g = 0; g < 2; g++) begin
                if (t >= len - 12) begin
                    ext_src[g] = 1'b0;
                end else begin
                    ph[g]++;
                    if (ph[g] == hp[g]) begin
                        ph[g] = 0;
                        if (!ext_src[g]) begin
                            rises[g]++;
                            if (frise[g] < 0) frise[g] = t;
                        end
                        ext_src[g] = ~ext_src[g];
                    end
                end
            end
        end
        for (int i = 0; i < 2; i++)
            for (int c = 0; c < 5; c++) begin
                int g;
                g = (c < 2) ? 0 : 1;
                pc = (c < 2) ? p0 : p1;
                code = int'(sel[4*c +: 4]);
                d = period_of(i, pc, code);
                if (d == 0) begin
                    check(cnt[i][c] == rises[g], "R5", {tag, " ext tick count"},
                          cnt[i][c], rises[g]);
                    if (rises[g] > 0)
                        check(first[i][c] == frise[g] + 3, "R6", {tag, " ext latency"},
                              first[i][c], frise[g] + 3);
                end else begin
                    check(first[i][c] == d, "R7", {tag, " first tick after restart"},
                          first[i][c], d);
                    check(bad[i][c] == 0, "R4", {tag, " tick interval (R2 R3)"},
                          bad[i][c], 0);
                    check(cnt[i][c] == (len - 1) / d, "R4", {tag, " tick count"},
                          cnt[i][c], (len - 1) / d);
                end
            end
    endtask

    initial begin
        int seed_dummy;
        int n;
        seed_dummy = int'($urandom(32'h5EED_1234));
        // R1: quiet while reset is held
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(tick_a == 5'd0 && tick_b == 5'd0, "R1", "ticks in reset",
                  int'({tick_a, tick_b}), 0);
        end
        rst_n = 1'b1;
        // R1: reset configuration is prescaler 0, code 0 on every channel
        @(negedge clk);
        n = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            check(tick_a == 5'h1F, "R1", "default divide-by-1", int'(tick_a), 31);
            if (tick_b == 5'h1F) n++;
        end
        check(n == 4, "R1", "default divide-by-2 count", n, 4);

        // R2: groups with different prescalers
        run_window(2, 5, {4'd2, 4'd3, 4'd0, 4'd1, 4'd0}, "groups");
        // R3: largest prescaler value
        run_window(255, 0, 20'h00000, "max prescale");
        // R5: codes that are external in one copy and dividers in the other
        run_window(1, 0, {4'd1, 4'd7, 4'd4, 4'd0, 4'd5}, "ext codes");
        run_window(0, 3, {4'd6, 4'd4, 4'd5, 4'd4, 4'd2}, "ext mix");
        // Constrained random windows
        for (int w = 0; w < 16; w++) begin
            int p0r, p1r;
            logic [19:0] s;
            p0r = int'($urandom % 4);
            p1r = int'($urandom % 4);
            s = 20'($urandom) & 20'h77777;
            run_window(p0r, p1r, s, "random");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule